// File: doc/BRIEF.md
# Best-Offset Prefetch Learning Engine

This block learns which single line-address offset would have made the most useful prefetch for a cache, and then generates prefetch line addresses with that offset. Every accepted demand access tests one candidate from a fixed table of offsets. The engine subtracts the candidate from the access line address and presents the result as a lookup tag to an external table of recently completed requests. That table answers with a hit in the same cycle. A hit raises the candidate's score.

Candidates are visited round-robin. A learning phase ends when one score reaches a ceiling or when enough full passes over the table have been made. At that point the phase winner becomes the active offset, but only if its score beats a bad-score threshold. Otherwise prefetching is switched off until a later phase does better.

While prefetching is on, each access produces `DEGREE` prefetch line addresses. They leave one per cycle on a valid/ready port. The recent-requests storage, the cache side and any queueing of prefetches lie outside the block.

The prefetch sequencer has two states, `S_IDLE` and `S_ISSUE`:
- `S_IDLE` accepts accesses.
- Idle-to-issue: an access is accepted while prefetching is on (after that access's own learning update).
- Issue-to-issue: each handshake with a count below `DEGREE`.
- Issue-to-idle: the handshake of the last prefetch.

Top module: `bo_prefetch_learner`

## Requirements
- R1: The offset table holds, in ascending order, the positive integers with no prime factor other than 2, 3 and 5, starting from 1. With `NEG_EN`=1 each positive value is followed directly by its negation, so 4 entries are 1, -1, 2, -2.
- R2: `lookup_tag` is combinational. It equals the low `TAG_W` bits of (`acc_line` minus the current offset), computed with modular wrap, so line 0 minus 1 gives all ones.
- R3: Each accepted access tests only the candidate at the table pointer, then moves the pointer to the next entry. Moving from the last entry back to the first adds one to the round count.
- R4: A hit adds one to the tested candidate's score (saturating). If the new score is strictly above the phase best score, that candidate becomes the phase best offset.
- R5: A phase ends on the access where the best score reaches `SCORE_MAX` or the round count reaches `ROUND_MAX`. The end clears all scores, the best score, the phase best offset and the round count. It leaves the table pointer where it is.
- R6: At a phase end, prefetching turns on and `best_offset` takes the phase winner only when the best score is strictly greater than `BAD_SCORE`. Otherwise prefetching turns off and `best_offset` keeps its value. Both outputs change only on accepted accesses.
- R7: After reset `best_offset` is 1, `pf_enable` is 0, `acc_ready` is 1 and `pf_valid` is 0.
- R8: An access accepted while prefetching is on (after its own update) yields `DEGREE` prefetches, `acc_line` + k·`best_offset` for k = 1..`DEGREE`, in increasing k, one per `pf_valid`/`pf_ready` handshake. The first appears the cycle after acceptance. Under stall, `pf_line` holds.
- R9: `acc_ready` is low while any prefetch of the previous access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present |
| acc_ready | output | 1 | Access can be taken this cycle |
| acc_line | input | LINE_W | Line address of the access |
| lookup_tag | output | TAG_W | Tag presented to the recent-requests table |
| lookup_hit | input | 1 | Table hit for `lookup_tag`, same cycle |
| pf_valid | output | 1 | Prefetch line address valid |
| pf_ready | input | 1 | Prefetch taken |
| pf_line | output | LINE_W | Prefetch line address |
| best_offset | output | OFF_W | Active offset, signed |
| pf_enable | output | 1 | Prefetching switched on |

## Verification
The bound checker checks these every cycle:
- a stalled prefetch holds its address;
- no access is accepted while prefetches are pending;
- prefetches only appear while prefetching is on;
- the enable and the active offset move only on accepted accesses;
- the active offset is never zero.

Only the directed scenarios can show the following:
- the offset table order and the wrapped tag arithmetic;
- phase ends caused by the score ceiling versus by the round limit;
- the strict comparison against the bad-score threshold, which needs a best score exactly equal to it;
- the exact sequence of prefetch addresses.

// File: rtl/bo_pkg.sv
package bo_pkg;

    // n-th (from 0) positive integer whose prime factors are only 2, 3 and 5
    function automatic int smooth_nth(input int n);
        int found;
        int cand;
        int v;
        found = 0;
        cand  = 0;
        while (found <= n) begin
            cand = cand + 1;
            v = cand;
            while (v % 2 == 0) v = v / 2;
            while (v % 3 == 0) v = v / 3;
            while (v % 5 == 0) v = v / 5;
            if (v == 1) found = found + 1;
        end
        return cand;
    endfunction

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } issue_state_e;

endpackage

// File: rtl/bo_offset_rom.sv
module bo_offset_rom #(
    parameter int NUM_OFF = 8,
    parameter int NEG_EN  = 0,
    parameter int OFF_W   = 8,
    parameter int PTR_W   = 3
) (
    input  logic [PTR_W-1:0]        ptr,
    output logic signed [OFF_W-1:0] off
);
    import bo_pkg::*;

    logic signed [OFF_W-1:0] tbl [NUM_OFF];

    // R1: ascending 2/3/5-smooth values, negation interleaved when enabled
    for (genvar i = 0; i < NUM_OFF; i++) begin : g_ent
        localparam int MAG = smooth_nth((NEG_EN != 0) ? (i / 2) : i);
        localparam int VAL = ((NEG_EN != 0) && (i % 2 == 1)) ? -MAG : MAG;
        assign tbl[i] = VAL[OFF_W-1:0];
    end

    assign off = tbl[ptr];
endmodule

// File: rtl/bo_learn.sv
module bo_learn #(
    parameter int NUM_OFF   = 8,
    parameter int OFF_W     = 8,
    parameter int PTR_W     = 3,
    parameter int SCORE_W   = 5,
    parameter int SCORE_MAX = 31,
    parameter int ROUND_MAX = 100,
    parameter int BAD_SCORE = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    hit,
    input  logic signed [OFF_W-1:0] cur_off,
    output logic [PTR_W-1:0]        ptr,
    output logic signed [OFF_W-1:0] best_q,
    output logic                    en_q,
    output logic signed [OFF_W-1:0] best_n,
    output logic                    en_n
);
    localparam int RND_W = $clog2(ROUND_MAX + 1);
    localparam logic [SCORE_W-1:0] SMAX     = SCORE_W'(SCORE_MAX);
    localparam logic [SCORE_W-1:0] SBAD     = SCORE_W'(BAD_SCORE);
    localparam logic [RND_W-1:0]   RMAX     = RND_W'(ROUND_MAX);
    localparam logic [PTR_W-1:0]   PTR_LAST = PTR_W'(NUM_OFF - 1);

    logic [SCORE_W-1:0]      score_q [NUM_OFF];
    logic [SCORE_W-1:0]      bscore_q, bscore_n, sc_cur, sc_inc;
    logic signed [OFF_W-1:0] pbest_q, pbest_n;
    logic [RND_W-1:0]        round_q, round_n;
    logic [PTR_W-1:0]        ptr_q;
    logic                    wrap, phase_end, good, take;

    always_comb begin
        sc_cur    = score_q[ptr_q];
        sc_inc    = (hit && (sc_cur != '1)) ? sc_cur + 1'b1 : sc_cur;
        take      = hit && (sc_inc > bscore_q);
        bscore_n  = take ? sc_inc : bscore_q;
        pbest_n   = take ? cur_off : pbest_q;
        wrap      = (ptr_q == PTR_LAST);
        round_n   = wrap ? round_q + 1'b1 : round_q;
        phase_end = (bscore_n >= SMAX) || (round_n >= RMAX);
        good      = (bscore_n > SBAD);
        en_n      = phase_end ? good : en_q;
        best_n    = (phase_end && good) ? pbest_n : best_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OFF; i++) score_q[i] <= '0;
            bscore_q <= '0;
            pbest_q  <= '0;
            round_q  <= '0;
            ptr_q    <= '0;
            best_q   <= OFF_W'(1);
            en_q     <= 1'b0;
        end else if (step) begin
            ptr_q  <= wrap ? '0 : ptr_q + 1'b1;
            en_q   <= en_n;
            best_q <= best_n;
            if (phase_end) begin
                for (int i = 0; i < NUM_OFF; i++) score_q[i] <= '0;
                bscore_q <= '0;
                pbest_q  <= '0;
                round_q  <= '0;
            end else begin
                score_q[ptr_q] <= sc_inc;
                bscore_q       <= bscore_n;
                pbest_q        <= pbest_n;
                round_q        <= round_n;
            end
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/bo_issue.sv
module bo_issue #(
    parameter int LINE_W = 32,
    parameter int OFF_W  = 8,
    parameter int DEGREE = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic [LINE_W-1:0]       acc_line,
    input  logic                    en_now,
    input  logic signed [OFF_W-1:0] best_now,
    input  logic                    pf_ready,
    output logic                    acc_ready,
    output logic                    pf_valid,
    output logic [LINE_W-1:0]       pf_line
);
    import bo_pkg::*;

    localparam int CNT_W = $clog2(DEGREE + 1);
    localparam logic [CNT_W-1:0] DEG_V = CNT_W'(DEGREE);

    issue_state_e      state_q, state_n;
    logic [LINE_W-1:0] addr_q, step_q, best_ext;
    logic [CNT_W-1:0]  cnt_q;
    logic              start, last;

    assign best_ext = LINE_W'(best_now);
    assign start    = acc_valid && (state_q == S_IDLE);
    assign last     = (cnt_q == DEG_V);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:  if (start && en_now) state_n = S_ISSUE;
            S_ISSUE: if (pf_ready && last) state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            step_q <= '0;
            cnt_q  <= '0;
        end else if (start && en_now) begin
            addr_q <= acc_line + best_ext;
            step_q <= best_ext;
            cnt_q  <= CNT_W'(1);
        end else if ((state_q == S_ISSUE) && pf_ready && !last) begin
            addr_q <= addr_q + step_q;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        acc_ready = 1'b0;
        pf_valid  = 1'b0;
        unique case (state_q)
            S_IDLE:  acc_ready = 1'b1;
            S_ISSUE: pf_valid  = 1'b1;
            default: ;
        endcase
        pf_line = addr_q;
    end
endmodule

// File: rtl/bo_prefetch_learner.sv
module bo_prefetch_learner #(
    parameter int LINE_W    = 32,
    parameter int TAG_W     = 12,
    parameter int OFF_W     = 8,
    parameter int NUM_OFF   = 8,
    parameter int NEG_EN    = 0,
    parameter int SCORE_W   = 5,
    parameter int SCORE_MAX = 31,
    parameter int ROUND_MAX = 100,
    parameter int BAD_SCORE = 1,
    parameter int DEGREE    = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    output logic                    acc_ready,
    input  logic [LINE_W-1:0]       acc_line,
    output logic [TAG_W-1:0]        lookup_tag,
    input  logic                    lookup_hit,
    output logic                    pf_valid,
    input  logic                    pf_ready,
    output logic [LINE_W-1:0]       pf_line,
    output logic signed [OFF_W-1:0] best_offset,
    output logic                    pf_enable
);
    localparam int PTR_W = (NUM_OFF > 1) ? $clog2(NUM_OFF) : 1;

    logic [PTR_W-1:0]        ptr;
    logic signed [OFF_W-1:0] cur_off, best_n;
    logic [TAG_W-1:0]        off_t;
    logic                    en_n, step;

    bo_offset_rom #(
        .NUM_OFF(NUM_OFF), .NEG_EN(NEG_EN), .OFF_W(OFF_W), .PTR_W(PTR_W)
    ) u_rom (
        .ptr(ptr), .off(cur_off)
    );

    // low bits of a wrapped full-width difference equal the wrapped low-bit difference
    assign off_t      = TAG_W'(cur_off);
    assign lookup_tag = acc_line[TAG_W-1:0] - off_t;
    assign step       = acc_valid && acc_ready;

    bo_learn #(
        .NUM_OFF(NUM_OFF), .OFF_W(OFF_W), .PTR_W(PTR_W), .SCORE_W(SCORE_W),
        .SCORE_MAX(SCORE_MAX), .ROUND_MAX(ROUND_MAX), .BAD_SCORE(BAD_SCORE)
    ) u_learn (
        .clk(clk), .rst_n(rst_n), .step(step), .hit(lookup_hit),
        .cur_off(cur_off), .ptr(ptr), .best_q(best_offset), .en_q(pf_enable),
        .best_n(best_n), .en_n(en_n)
    );

    bo_issue #(
        .LINE_W(LINE_W), .OFF_W(OFF_W), .DEGREE(DEGREE)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
        .en_now(en_n), .best_now(best_n), .pf_ready(pf_ready),
        .acc_ready(acc_ready), .pf_valid(pf_valid), .pf_line(pf_line)
    );
endmodule

// File: rtl/bo_prefetch_learner_chk.sv
module bo_prefetch_learner_chk #(
    parameter int LINE_W = 32,
    parameter int OFF_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic                    acc_ready,
    input logic                    pf_valid,
    input logic                    pf_ready,
    input logic [LINE_W-1:0]       pf_line,
    input logic signed [OFF_W-1:0] best_offset,
    input logic                    pf_enable
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

    assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !acc_ready);

    assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> pf_enable);

    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_ready) |=> ($stable(pf_enable) && $stable(best_offset)));

    assert_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        best_offset != '0);
endmodule

bind bo_prefetch_learner bo_prefetch_learner_chk #(
    .LINE_W(LINE_W), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line),
    .best_offset(best_offset), .pf_enable(pf_enable)
);

// File: tb/test_bo_prefetch_learner.sv
`timescale 1ns/1ps
module test_bo_prefetch_learner;
    localparam int LINE_W = 32;
    localparam int TAG_W  = 12;
    localparam int OFF_W  = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    acc_valid = 1'b0;
    logic                    acc_ready;
    logic [LINE_W-1:0]       acc_line = '0;
    logic [TAG_W-1:0]        lookup_tag;
    logic                    lookup_hit = 1'b0;
    logic                    pf_valid;
    logic                    pf_ready = 1'b1;
    logic [LINE_W-1:0]       pf_line;
    logic signed [OFF_W-1:0] best_offset;
    logic                    pf_enable;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bo_prefetch_learner #(
        .LINE_W(LINE_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .NUM_OFF(4), .NEG_EN(1),
        .SCORE_W(4), .SCORE_MAX(3), .ROUND_MAX(4), .BAD_SCORE(1), .DEGREE(2)
    ) i_bo_prefetch_learner (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_line(acc_line), .lookup_tag(lookup_tag), .lookup_hit(lookup_hit),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line),
        .best_offset(best_offset), .pf_enable(pf_enable)
    );

    // R1: table for NUM_OFF=4 with negation enabled
    function automatic int off_at(input int idx);
        case (idx % 4)
            0: return 1;
            1: return -1;
            2: return 2;
            default: return -2;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one access; n_pf prefetches expected with step pf_step; optional stall cycles
    task automatic do_access(input logic [31:0] addr, input bit hit, input int idx,
                             input int n_pf, input int pf_step, input int stall,
                             input string req);
        logic [31:0] exp_tag;
        logic [31:0] exp_line;
        exp_tag = (addr - 32'(off_at(idx))) & 32'hFFF;
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_line   = addr;
        lookup_hit = hit;
        #1;
        chk(acc_ready == 1'b1, {req, " R9 ready before access"}, acc_ready, 1);
        chk(lookup_tag == exp_tag[TAG_W-1:0], {req, " R2 lookup tag"}, lookup_tag, exp_tag);
        @(posedge clk);
        @(negedge clk);
        acc_valid  = 1'b0;
        lookup_hit = 1'b0;
        if (stall > 0) begin
            pf_ready = 1'b0;
            exp_line = addr + 32'(pf_step);
            for (int s = 0; s < stall; s++) begin
                #1;
                chk(pf_valid && (pf_line == exp_line), {req, " R8 held under stall"}, pf_line, exp_line);
                chk(acc_ready == 1'b0, {req, " R9 blocked while pending"}, acc_ready, 0);
                @(negedge clk);
            end
            pf_ready = 1'b1;
        end
        for (int k = 1; k <= n_pf; k++) begin
            exp_line = addr + 32'(k * pf_step);
            #1;
            chk(pf_valid == 1'b1, {req, " R8 prefetch valid"}, pf_valid, 1);
            chk(pf_line == exp_line, {req, " R8 prefetch line"}, pf_line, exp_line);
            @(negedge clk);
        end
        #1;
        chk(pf_valid == 1'b0, {req, " R8 prefetch count"}, pf_valid, 0);
        chk(acc_ready == 1'b1, {req, " R9 ready again"}, acc_ready, 1);
    endtask

    task automatic t_reset();
        #1;
        chk(best_offset == 8'sd1, "R7 best offset", best_offset, 1);
        chk(pf_enable == 1'b0, "R7 enable", pf_enable, 0);
        chk(acc_ready == 1'b1, "R7 ready", acc_ready, 1);
        chk(pf_valid == 1'b0, "R7 prefetch valid", pf_valid, 0);
    endtask

    // R1 R2 R3 R5 R6: no hits for ROUND_MAX rounds, phase ends disabled
    task automatic t_round_limit_nohit();
        for (int j = 0; j < 16; j++) begin
            logic [31:0] a;
            a = (j == 0) ? 32'h0 : 32'h100 + 32'(j * 16);
            do_access(a, 1'b0, j, 0, 0, 0, "R1 table walk");
        end
        chk(pf_enable == 1'b0, "R5 round limit with zero score", pf_enable, 0);
        chk(best_offset == 8'sd1, "R6 offset kept", best_offset, 1);
    endtask

    // R4 R5 R6 R8: only offset 2 hits; third hit reaches SCORE_MAX mid-round
    task automatic t_score_limit();
        for (int j = 0; j <= 10; j++) begin
            logic [31:0] a;
            a = 32'h2000 + 32'(j * 64);
            do_access(a, (j % 4) == 2, j, (j == 10) ? 2 : 0, 2, 0, "R4 score limit");
        end
        chk(pf_enable == 1'b1, "R5 score limit enables", pf_enable, 1);
        chk(best_offset == 8'sd2, "R4 winner offset", best_offset, 2);
    endtask

    // R8 R9: pointer now at index 3; stalled prefetch output
    task automatic t_stall();
        do_access(32'h5000, 1'b0, 3, 2, 2, 3, "R8 stall");
    endtask

    // R6: best score equal to BAD_SCORE at round limit disables, offset kept
    task automatic t_threshold();
        for (int j = 0; j < 12; j++) begin
            logic [31:0] a;
            a = 32'h8000 - 32'(j * 32);
            do_access(a, j == 0, j, (j == 11) ? 0 : 2, 2, 0, "R6 threshold");
        end
        chk(pf_enable == 1'b0, "R6 equal to threshold disables", pf_enable, 0);
        chk(best_offset == 8'sd2, "R6 offset retained", best_offset, 2);
        do_access(32'h9000, 1'b0, 0, 0, 0, 0, "R3 pointer after phase end");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_round_limit_nohit();
        t_score_limit();
        t_stall();
        t_threshold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule